// File: doc/BRIEF.md
# Oversampled I2C Slave Front End for a Serial Memory

This block sits between a two-wire serial bus and the sequencer of a byte-wide nonvolatile memory. It samples SCL and SDA with the system clock and finds START and STOP conditions. It shifts bytes in and out most significant bit first and drives the acknowledge bit. The memory sequencer behind it only sees single-cycle strobes: a byte arrived, the device was selected (with direction and high address bits), a byte to send was taken, and the master did or did not acknowledge.

SDA is never driven high. The block only controls an output enable, and while the enable is set the pad pulls the line low. The select byte is the fixed prefix `1010`, then three select bits, then the direction bit. The parameter `HI_ADDR_BITS` (0 to 3) sets how many of the lowest select bits act as upper memory address bits. The remaining select bits must equal the strap pins. The values 0, 1, 2 and 3 correspond to the 2K, 4K, 8K and 16K density variants. While the sequencer holds `busy_i` high, for example during an internal program cycle, the select byte gets no acknowledge, so a polling master sees the device as absent.

The controller has eight states:

| State | Role | Transitions |
|---|---|---|
| IDLE | Wait for a START. | START → SEL |
| SEL | Collect the select byte. | After the eighth bit → SEL_ACK on a match with busy low, otherwise → HOLD |
| SEL_ACK | Drive the ninth-clock acknowledge. | Direction bit 0 → WR; direction bit 1 → RD |
| WR | Collect a write byte. | → WR_ACK |
| WR_ACK | Acknowledge the write byte. | → WR |
| RD | Shift out a byte. | → RD_ACK |
| RD_ACK | Sample the master's answer. | Acknowledge → RD; no acknowledge → HOLD |
| HOLD | Ignore the bus. | Leaves only on START or STOP |

From every state, a START goes to SEL and a STOP goes to IDLE.

Top module: `i2c_mem_slave_fe`

## Requirements
- R1: A falling SDA while SCL is high raises `start_o` for one cycle. A rising SDA while SCL is high raises `stop_o` for one cycle. The two are never high together.
- R2: Before the first START, bytes clocked on the bus get no acknowledge and raise no strobe.
- R3: The select byte is `1010`, then select bits s2 s1 s0, then the direction bit, sent MSB first. On a selected byte, `rw_o` holds the direction bit: 1 means read and 0 means write.
- R4: Each select bit si with index i ≥ `HI_ADDR_BITS` must equal `strap_i[i]`. On a prefix or strap mismatch, the block gives no acknowledge and ignores the bus until the next START or STOP.
- R5: With `sel_o`, bit i of `hi_addr_o` equals si for each i < `HI_ADDR_BITS`. All other bits of `hi_addr_o` are 0.
- R6: The block acknowledges a selected select byte and every byte received in write mode by setting `sda_oe_o` during the ninth SCL clock. Each write byte raises `rx_valid_o` for one cycle with the byte on `rx_byte_o`.
- R7: In read mode, the block takes `tx_data_i` when it pulses `tx_load_o` and sends it MSB first. `sda_oe_o` equals the inverse of the bit being sent.
- R8: On the ninth clock of a read byte, SDA low raises `mack_o` and the next byte follows. SDA high raises `nack_o`, and SDA stays released until a START or STOP.
- R9: While `busy_i` is high, the select byte gets no acknowledge and `sel_o` stays low.
- R10: A START in the middle of a byte discards the partial byte and restarts select-byte reception.
- R11: `sda_oe_o` rises only while SCL is low.
- R12: After reset, `sda_oe_o` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data as seen on the pad |
| sda_oe_o | output | 1 | Pull SDA low while 1 |
| strap_i | input | 3 | Device strap pins, bit i compared with select bit si |
| busy_i | input | 1 | Sequencer busy; suppresses the select acknowledge |
| tx_data_i | input | 8 | Next byte to transmit |
| start_o | output | 1 | START seen (pulse) |
| stop_o | output | 1 | STOP seen (pulse) |
| sel_o | output | 1 | Device selected and acknowledged (pulse) |
| rw_o | output | 1 | Direction of the current transfer, 1 = read |
| hi_addr_o | output | 3 | Upper memory address bits taken from the select byte |
| rx_valid_o | output | 1 | Write byte received (pulse) |
| rx_byte_o | output | 8 | Last write byte |
| tx_load_o | output | 1 | `tx_data_i` taken for sending (pulse) |
| mack_o | output | 1 | Master acknowledged a read byte (pulse) |
| nack_o | output | 1 | Master did not acknowledge a read byte (pulse) |

## Verification
The bench drives SCL and SDA as a bus master and targets the following corner cases:

- **Select bytes before any START.** A block that fails to gate on START would acknowledge them.
- **A strap mismatch followed by data.** A block that fails to return to an ignoring state would acknowledge the data and report it as a write.
- **A master's no-acknowledge after a read byte.** A block that keeps transmitting would pull the line during the following clocks.
- **A repeated START part-way through a write byte.** A block that keeps its bit counter would misframe the next select byte, or would deliver the partial byte.
- **A busy-poll cycle and a variant that takes all select bits as address.** These show whether the busy gating and the address pass-through follow the parameter.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_SEL_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_HOLD
    } fe_state_t;

    localparam logic [3:0] SEL_PREFIX = 4'b1010;
    localparam int         BYTE_W     = 8;
    localparam int         SEL_W      = 3;

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    localparam int CHAIN_W = W * (STAGES + 1);

    logic [CHAIN_W-1:0] chain;

    // element k lives at chain[W*k +: W]; element 0 is the first flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN_W-W-1:0], d};
    end

    assign q      = chain[W*(STAGES-1) +: W];
    assign q_prev = chain[W*STAGES +: W];
endmodule

// File: rtl/fe_cond_det.sv
module fe_cond_det (
    input  logic scl_q,
    input  logic scl_p,
    input  logic sda_q,
    input  logic sda_p,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_held_high;

    assign scl_held_high = scl_q & scl_p;
    assign start_det     = scl_held_high & sda_p & ~sda_q;
    assign stop_det      = scl_held_high & ~sda_p & sda_q;
    assign scl_rise      = scl_q & ~scl_p;
    assign scl_fall      = ~scl_q & scl_p;
endmodule

// File: rtl/fe_sel_match.sv
module fe_sel_match
    import fe_pkg::*;
#(
    parameter int HI_ADDR_BITS = 0
) (
    input  logic [7:1]       sel_byte,
    input  logic [SEL_W-1:0] strap,
    output logic             match,
    output logic [SEL_W-1:0] hi_addr
);
    logic [SEL_W-1:0] bit_ok;

    for (genvar i = 0; i < SEL_W; i++) begin : g_selbit
        if (i < HI_ADDR_BITS) begin : g_addr
            assign bit_ok[i]  = 1'b1;
            assign hi_addr[i] = sel_byte[i+1];
        end else begin : g_strap
            assign bit_ok[i]  = (sel_byte[i+1] == strap[i]);
            assign hi_addr[i] = 1'b0;
        end
    end

    assign match = (sel_byte[7:4] == SEL_PREFIX) && (&bit_ok);
endmodule

// File: rtl/i2c_mem_slave_fe.sv
module i2c_mem_slave_fe
    import fe_pkg::*;
#(
    parameter int HI_ADDR_BITS = 0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [SEL_W-1:0]    strap_i,
    input  logic                busy_i,
    input  logic [BYTE_W-1:0]   tx_data_i,
    output logic                start_o,
    output logic                stop_o,
    output logic                sel_o,
    output logic                rw_o,
    output logic [SEL_W-1:0]    hi_addr_o,
    output logic                rx_valid_o,
    output logic [BYTE_W-1:0]   rx_byte_o,
    output logic                tx_load_o,
    output logic                mack_o,
    output logic                nack_o
);
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [1:0] sy_q, sy_p;
    logic       scl_q, sda_q;
    logic       start_det, stop_det, scl_rise, scl_fall;
    logic       sel_match, sel_ok;
    logic [SEL_W-1:0] sel_hi;

    fe_state_t        state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic             byte_full;

    fe_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({scl_i, sda_i}),
        .q      (sy_q),
        .q_prev (sy_p)
    );

    assign scl_q = sy_q[1];
    assign sda_q = sy_q[0];

    fe_cond_det u_cond (
        .scl_q     (sy_q[1]),
        .scl_p     (sy_p[1]),
        .sda_q     (sy_q[0]),
        .sda_p     (sy_p[0]),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    fe_sel_match #(.HI_ADDR_BITS(HI_ADDR_BITS)) u_match (
        .sel_byte (shreg[7:1]),
        .strap    (strap_i),
        .match    (sel_match),
        .hi_addr  (sel_hi)
    );

    assign sel_ok    = sel_match && !busy_i;
    assign byte_full = (bit_cnt == CNT_FULL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_SEL;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_SEL:     if (scl_fall && byte_full)
                                state_nx = sel_ok ? ST_SEL_ACK : ST_HOLD;
                ST_SEL_ACK: if (scl_fall)
                                state_nx = rw_o ? ST_RD : ST_WR;
                ST_WR:      if (scl_fall && byte_full) state_nx = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall) state_nx = ST_WR;
                ST_RD:      if (scl_fall && byte_full) state_nx = ST_RD_ACK;
                ST_RD_ACK:  if (scl_rise && scl_q && sda_q) state_nx = ST_HOLD;
                            else if (scl_fall) state_nx = ST_RD;
                ST_HOLD:    state_nx = ST_HOLD;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            sda_oe_o   <= 1'b0;
            start_o    <= 1'b0;
            stop_o     <= 1'b0;
            sel_o      <= 1'b0;
            rw_o       <= 1'b0;
            hi_addr_o  <= '0;
            rx_valid_o <= 1'b0;
            rx_byte_o  <= '0;
            tx_load_o  <= 1'b0;
            mack_o     <= 1'b0;
            nack_o     <= 1'b0;
        end else begin
            start_o    <= 1'b0;
            stop_o     <= 1'b0;
            sel_o      <= 1'b0;
            rx_valid_o <= 1'b0;
            tx_load_o  <= 1'b0;
            mack_o     <= 1'b0;
            nack_o     <= 1'b0;
            if (stop_det) begin
                stop_o   <= 1'b1;
                sda_oe_o <= 1'b0;
                bit_cnt  <= '0;
            end else if (start_det) begin
                start_o  <= 1'b1;
                sda_oe_o <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                unique case (state)
                    ST_SEL, ST_WR: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_q};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (state == ST_WR && bit_cnt == CNT_LAST) begin
                                rx_byte_o  <= {shreg[BYTE_W-2:0], sda_q};
                                rx_valid_o <= 1'b1;
                            end
                        end
                        if (scl_fall && byte_full) begin
                            if (state == ST_WR) begin
                                sda_oe_o <= 1'b1;
                            end else if (sel_ok) begin
                                sda_oe_o  <= 1'b1;
                                sel_o     <= 1'b1;
                                rw_o      <= shreg[0];
                                hi_addr_o <= sel_hi;
                            end
                        end
                    end
                    ST_SEL_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_o) begin
                                shreg     <= tx_data_i;
                                sda_oe_o  <= ~tx_data_i[BYTE_W-1];
                                tx_load_o <= 1'b1;
                            end else begin
                                sda_oe_o  <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe_o <= 1'b0;
                            bit_cnt  <= '0;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise && !byte_full) bit_cnt <= bit_cnt + 1'b1;
                        if (scl_fall) begin
                            if (byte_full) begin
                                sda_oe_o <= 1'b0;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe_o <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            if (sda_q) nack_o <= 1'b1;
                            else       mack_o <= 1'b1;
                        end else if (scl_fall) begin
                            bit_cnt   <= '0;
                            shreg     <= tx_data_i;
                            sda_oe_o  <= ~tx_data_i[BYTE_W-1];
                            tx_load_o <= 1'b1;
                        end
                    end
                    ST_IDLE, ST_HOLD: begin
                        sda_oe_o <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/fe_chk.sv
module fe_chk #(
    parameter int HI_ADDR_BITS = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       busy_i,
    input logic [7:0] tx_data_i,
    input logic       sda_oe_o,
    input logic       start_o,
    input logic       stop_o,
    input logic       sel_o,
    input logic       rw_o,
    input logic [2:0] hi_addr_o,
    input logic       rx_valid_o,
    input logic       tx_load_o,
    input logic       nack_o
);
    // R1
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    // R9
    busy_blocks_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> !$past(busy_i));

    // R6
    rx_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !rw_o);

    // R11
    oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R5
    hi_addr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> ((hi_addr_o >> HI_ADDR_BITS) == 3'b000));

    // R8
    nack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_o |=> !sda_oe_o);

    // R7
    tx_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> (sda_oe_o == !$past(tx_data_i[7])));
endmodule

bind i2c_mem_slave_fe fe_chk #(.HI_ADDR_BITS(HI_ADDR_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .busy_i     (busy_i),
    .tx_data_i  (tx_data_i),
    .sda_oe_o   (sda_oe_o),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .sel_o      (sel_o),
    .rw_o       (rw_o),
    .hi_addr_o  (hi_addr_o),
    .rx_valid_o (rx_valid_o),
    .tx_load_o  (tx_load_o),
    .nack_o     (nack_o)
);

// File: tb/sim_i2c_mem_slave_fe.sv
`timescale 1ns/1ps
module sim_i2c_mem_slave_fe;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic busy0 = 1'b0;
    int   tgt = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    logic       oe0, oe1, sda0, sda1;
    logic       st0, sp0, sel0, rw0, rxv0, txl0, mk0, nk0;
    logic [2:0] hi0;
    logic [7:0] rxb0;
    logic       st1, sp1, sel1, rw1, rxv1, txl1, mk1, nk1;
    logic [2:0] hi1;
    logic [7:0] rxb1;
    logic [7:0] tx0 = 8'hA5;

    assign sda0 = m_sda & ~oe0;
    assign sda1 = m_sda & ~oe1;

    i2c_mem_slave_fe u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda0), .sda_oe_o(oe0),
        .strap_i(3'b101), .busy_i(busy0), .tx_data_i(tx0),
        .start_o(st0), .stop_o(sp0), .sel_o(sel0), .rw_o(rw0), .hi_addr_o(hi0),
        .rx_valid_o(rxv0), .rx_byte_o(rxb0), .tx_load_o(txl0),
        .mack_o(mk0), .nack_o(nk0)
    );

    i2c_mem_slave_fe #(.HI_ADDR_BITS(3)) u1 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda1), .sda_oe_o(oe1),
        .strap_i(3'b000), .busy_i(1'b0), .tx_data_i(8'h00),
        .start_o(st1), .stop_o(sp1), .sel_o(sel1), .rw_o(rw1), .hi_addr_o(hi1),
        .rx_valid_o(rxv1), .rx_byte_o(rxb1), .tx_load_o(txl1),
        .mack_o(mk1), .nack_o(nk1)
    );

    int n_start = 0, n_stop = 0, n_sel = 0, n_rx = 0, n_mack = 0, n_nack = 0;
    int n_oe_bad = 0, n_strobe = 0;
    logic [7:0] last_rx = 8'h00;

    always @(posedge clk) begin
        if (st0)  n_start++;
        if (sp0)  n_stop++;
        if (sel0) n_sel++;
        if (mk0)  n_mack++;
        if (nk0)  n_nack++;
        if (rxv0) begin n_rx++; last_rx <= rxb0; end
        if (txl0) tx0 <= tx0 + 8'h3C;
        if (st0 | sp0 | sel0 | rxv0 | txl0 | mk0 | nk0) n_strobe++;
        if (rst_n && oe0 && m_scl && !$past(oe0)) n_oe_bad++;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic line();
        return (tgt == 0) ? sda0 : sda1;
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(2*Q);
    endtask

    task automatic bit_io(input logic b, output logic r);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(Q);
        r = line(); wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_io(d[i], r);
        bit_io(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin bit_io(1'b1, r); d[i] = r; end
        bit_io(!give_ack, r);
    endtask

    task automatic t_reset();
        chk("R12 oe after reset", oe0, 1'b0);
        chk("R12 strobes after reset", n_strobe, 0);
    endtask

    task automatic t_no_start();
        logic ack;
        m_scl = 1'b0; wq(Q);
        send_byte(8'hAA, ack);
        chk("R2 no ack before START", ack, 1'b0);
        chk("R2 no sel before START", n_sel, 0);
        bus_stop();
    endtask

    task automatic t_write();
        logic ack;
        int s0 = n_start, p0 = n_stop, r0 = n_rx;
        bus_start();
        chk("R1 start pulse", n_start, s0 + 1);
        send_byte(8'hAA, ack);
        chk("R6 select ack", ack, 1'b1);
        chk("R3 rw write", rw0, 1'b0);
        send_byte(8'h5C, ack);
        chk("R6 data ack", ack, 1'b1);
        chk("R6 rx byte", last_rx, 8'h5C);
        send_byte(8'h03, ack);
        chk("R6 rx count", n_rx, r0 + 2);
        bus_stop();
        chk("R1 stop pulse", n_stop, p0 + 1);
    endtask

    task automatic t_mismatch();
        logic ack;
        int r0 = n_rx;
        bus_start();
        send_byte(8'hA8, ack);
        chk("R4 strap mismatch nack", ack, 1'b0);
        send_byte(8'hFF, ack);
        chk("R4 data ignored nack", ack, 1'b0);
        chk("R4 no rx strobe", n_rx, r0);
        bus_stop();
    endtask

    task automatic t_read();
        logic ack, r;
        logic [7:0] d;
        int m0 = n_mack, k0 = n_nack;
        bus_start();
        send_byte(8'hAB, ack);
        chk("R3 read select ack", ack, 1'b1);
        chk("R3 rw read", rw0, 1'b1);
        recv_byte(1'b1, d);
        chk("R7 first read byte", d, 8'hA5);
        chk("R8 master ack strobe", n_mack, m0 + 1);
        recv_byte(1'b0, d);
        chk("R7 second read byte", d, 8'hE1);
        chk("R8 nack strobe", n_nack, k0 + 1);
        bit_io(1'b1, r);
        bit_io(1'b1, r);
        chk("R8 line released after nack", r, 1'b1);
        bus_stop();
    endtask

    task automatic t_busy();
        logic ack;
        int s0 = n_sel;
        busy0 = 1'b1;
        bus_start();
        send_byte(8'hAA, ack);
        chk("R9 busy nack", ack, 1'b0);
        chk("R9 no sel while busy", n_sel, s0);
        bus_stop();
        busy0 = 1'b0;
        bus_start();
        send_byte(8'hAA, ack);
        chk("R9 ack after busy clears", ack, 1'b1);
        bus_stop();
    endtask

    task automatic t_rstart();
        logic ack, r;
        logic [7:0] d;
        int r0 = n_rx;
        bus_start();
        send_byte(8'hAA, ack);
        bit_io(1'b1, r); bit_io(1'b0, r); bit_io(1'b1, r); bit_io(1'b1, r);
        bus_start();
        send_byte(8'hAB, ack);
        chk("R10 select after repeated START", ack, 1'b1);
        chk("R10 partial byte dropped", n_rx, r0);
        recv_byte(1'b0, d);
        chk("R10 read after repeated START", d, 8'h1D);
        bus_stop();
    endtask

    task automatic t_hiaddr();
        logic ack;
        tgt = 1;
        bus_start();
        send_byte(8'hAC, ack);
        chk("R5 all-address variant ack", ack, 1'b1);
        chk("R5 high address bits", hi1, 3'b110);
        chk("R5 strap variant keeps zero", hi0, 3'b000);
        bus_stop();
        tgt = 0;
    endtask

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_no_start();
        t_write();
        t_mismatch();
        t_read();
        t_busy();
        t_rstart();
        t_hiaddr();
        chk("R11 oe rose with SCL high", n_oe_bad, 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule